// File: doc/BRIEF.md
# Parallel Pixel Front End

This block sits at the edge of a camera capture path and runs in the pixel clock domain. On every clock edge it decides whether the parallel bus carries a pixel. That is the case when both the line reference (`hRef`) and the frame reference (`vRef`) are high, the format code is one the block knows, and, when cropping is on, the pixel lies inside a programmed rectangle. Each accepted pixel is registered and presented with a valid strobe one cycle later.

A format select decides how the sample is placed on the 12-bit output. A 12-bit sample passes straight through. A 10-bit or 8-bit sample is pushed up to the most significant bits. The bits freed at the bottom are filled with zeros, or with a copy of the top of the sample when `fillRep` is set. A wide passthrough format copies the whole 40-bit input to a separate wide output, for serial-camera data that needs no alignment.

Registered copies of both references and a field flag go out with the data, so later stages can find line and frame boundaries on the same cycle as the pixels.

Top module: `pix_front_end`

## Requirements
- R1: A pixel is accepted on a rising clock edge only if `hRef` and `vRef` are both high at that edge. `hRef` alone or `vRef` alone never produces `outValid`.
- R2: Latency is exactly one cycle. `outValid`, `outData`, `outWide`, `outHsync` and `outVsync` reflect the inputs sampled at the previous rising edge.
- R3: When `cropEn` is 1, a pixel is accepted only if `hStart <= col <= hEnd` and `vStart <= line <= vEnd`. `col` is 0 on the cycle `hRef` rises and counts up by one on each further cycle with `hRef` high. `line` is 0 after a rising edge of `vRef` (also when `hRef` rises in the same cycle) and counts up by one at each falling edge of `hRef` seen while `vRef` is high.
- R4: Format codes 0 (raw 12-bit) and 4 (mono 12-bit) put `pixData[11:0]` on `outData[11:0]` unchanged.
- R5: Format codes 1 (raw 10-bit) and 3 (YUV 10-bit) put `pixData[9:0]` on `outData[11:2]`. `outData[1:0]` is `pixData[9:8]` when `fillRep` is 1, and 0 when `fillRep` is 0.
- R6: Format code 2 (YUV 8-bit) puts `pixData[7:0]` on `outData[11:4]`. `outData[3:0]` is `pixData[7:4]` when `fillRep` is 1, and 0 when `fillRep` is 0.
- R7: Format code 5 (wide passthrough) copies all 40 bits of `pixData` to `outWide`, with `outData` held at 0.
- R8: Format codes 6 and 7 never raise `outValid`.
- R9: On every cycle with `outValid` low, `outData` and `outWide` are 0. In non-wide formats, `outWide` is 0 as well.
- R10: `outField` toggles one cycle after each rising edge of `vRef`.
- R11: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixData | input | 40 | Raw pixel bus, sample right-justified |
| hRef | input | 1 | Line reference, high during active pixels |
| vRef | input | 1 | Frame reference, high during an active frame |
| fmtSel | input | 3 | Format code (0 to 5 valid) |
| fillRep | input | 1 | 1: low bits copy sample top bits, 0: zero fill |
| cropEn | input | 1 | Enables the crop window |
| hStart | input | 12 | First accepted column |
| hEnd | input | 12 | Last accepted column |
| vStart | input | 12 | First accepted line |
| vEnd | input | 12 | Last accepted line |
| outData | output | 12 | Aligned pixel |
| outWide | output | 40 | Wide passthrough pixel |
| outValid | output | 1 | Pixel strobe |
| outField | output | 1 | Field flag |
| outHsync | output | 1 | Delayed `hRef` |
| outVsync | output | 1 | Delayed `vRef` |

## Verification
The tricky coincidence is a frame start and a line start in the same cycle. Both counters must then restart together, and the pixel on that edge is judged against a crop window whose lower corner is at column 0, line 0. The bench provokes this by raising `vRef` and `hRef` on the same edge, with a window of exactly one pixel at (0,0). Its scoreboard expects `outValid` for that single pixel only, with the field flag toggling in the same output cycle. A wider window is also placed with its edges on interior columns and lines, so that the inclusive bounds are checked on both sides.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  typedef enum logic [2:0] {
    FMT_RAW12  = 3'd0,
    FMT_RAW10  = 3'd1,
    FMT_YUV8   = 3'd2,
    FMT_YUV10  = 3'd3,
    FMT_MONO12 = 3'd4,
    FMT_WIDE   = 3'd5
  } pixFmt_e;

  // alignment variant: 0 = full width, 1 = two pad bits, 2 = four pad bits
  typedef struct packed {
    logic       capture;
    logic       wide;
    logic [1:0] align;
    logic       fieldFlip;
  } ctlStrobe_t;

endpackage

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
  import pfe_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hRef,
  input  logic             vRef,
  input  logic [2:0]       fmtSel,
  input  logic             cropEn,
  input  logic [CNT_W-1:0] hStart,
  input  logic [CNT_W-1:0] hEnd,
  input  logic [CNT_W-1:0] vStart,
  input  logic [CNT_W-1:0] vEnd,
  output ctlStrobe_t       ctl
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hPrev, vPrev;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic             hRise, hFall, vRise;
  logic [CNT_W-1:0] hIdx, vIdx;
  logic             inWin, fmtOk, isWide;
  logic [1:0]       alignSel;

  assign hRise = hRef & ~hPrev;
  assign hFall = ~hRef & hPrev;
  assign vRise = vRef & ~vPrev;
  assign hIdx  = hRise ? '0 : hCnt;
  assign vIdx  = vRise ? '0 : vCnt;

  assign inWin = (hIdx >= hStart) && (hIdx <= hEnd) &&
                 (vIdx >= vStart) && (vIdx <= vEnd);

  always_comb begin
    fmtOk    = 1'b1;
    isWide   = 1'b0;
    alignSel = 2'd0;
    case (pixFmt_e'(fmtSel))
      FMT_RAW12, FMT_MONO12: alignSel = 2'd0;
      FMT_RAW10, FMT_YUV10:  alignSel = 2'd1;
      FMT_YUV8:              alignSel = 2'd2;
      FMT_WIDE:              isWide   = 1'b1;
      default:               fmtOk    = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
      hCnt  <= '0;
      vCnt  <= '0;
    end else begin
      hPrev <= hRef;
      vPrev <= vRef;
      if (hRef) hCnt <= (hIdx == CNT_MAX) ? CNT_MAX : hIdx + 1'b1;
      if (vRise)
        vCnt <= '0;
      else if (vRef && hFall && vCnt != CNT_MAX)
        vCnt <= vCnt + 1'b1;
    end
  end

  assign ctl.capture   = hRef & vRef & fmtOk & (~cropEn | inWin);
  assign ctl.wide      = isWide;
  assign ctl.align     = alignSel;
  assign ctl.fieldFlip = vRise;

endmodule

// File: rtl/pfe_datapath.sv
module pfe_datapath
  import pfe_pkg::*;
#(
  parameter int OUT_W  = 12,
  parameter int WIDE_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [WIDE_W-1:0] pixData,
  input  logic              fillRep,
  input  logic              hRef,
  input  logic              vRef,
  output logic [OUT_W-1:0]  outData,
  output logic [WIDE_W-1:0] outWide,
  output logic              outValid,
  output logic              outField,
  output logic              outHsync,
  output logic              outVsync
);

  localparam int N_VAR = 3;

  logic [OUT_W-1:0] cand [N_VAR];
  logic [OUT_W-1:0] alignedPix;

  for (genvar g = 0; g < N_VAR; g++) begin : g_align
    localparam int SW  = OUT_W - 2 * g;
    localparam int PAD = OUT_W - SW;
    if (PAD == 0) begin : g_full
      assign cand[g] = pixData[OUT_W-1:0];
    end else begin : g_pad
      assign cand[g] = {pixData[SW-1:0],
                        fillRep ? pixData[SW-1 -: PAD] : {PAD{1'b0}}};
    end
  end

  always_comb begin
    case (ctl.align)
      2'd1:    alignedPix = cand[1];
      2'd2:    alignedPix = cand[2];
      default: alignedPix = cand[0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outWide  <= '0;
      outValid <= 1'b0;
      outField <= 1'b0;
      outHsync <= 1'b0;
      outVsync <= 1'b0;
    end else begin
      outValid <= ctl.capture;
      outData  <= (ctl.capture && !ctl.wide) ? alignedPix : '0;
      outWide  <= (ctl.capture && ctl.wide) ? pixData : '0;
      outHsync <= hRef;
      outVsync <= vRef;
      if (ctl.fieldFlip) outField <= ~outField;
    end
  end

endmodule

// File: rtl/pix_front_end.sv
module pix_front_end
  import pfe_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int OUT_W  = 12,
  parameter int WIDE_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDE_W-1:0] pixData,
  input  logic              hRef,
  input  logic              vRef,
  input  logic [2:0]        fmtSel,
  input  logic              fillRep,
  input  logic              cropEn,
  input  logic [CNT_W-1:0]  hStart,
  input  logic [CNT_W-1:0]  hEnd,
  input  logic [CNT_W-1:0]  vStart,
  input  logic [CNT_W-1:0]  vEnd,
  output logic [OUT_W-1:0]  outData,
  output logic [WIDE_W-1:0] outWide,
  output logic              outValid,
  output logic              outField,
  output logic              outHsync,
  output logic              outVsync
);

  ctlStrobe_t ctl;

  pfe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hRef(hRef), .vRef(vRef), .fmtSel(fmtSel),
    .cropEn(cropEn), .hStart(hStart), .hEnd(hEnd), .vStart(vStart),
    .vEnd(vEnd), .ctl(ctl)
  );

  pfe_datapath #(.OUT_W(OUT_W), .WIDE_W(WIDE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixData(pixData),
    .fillRep(fillRep), .hRef(hRef), .vRef(vRef), .outData(outData),
    .outWide(outWide), .outValid(outValid), .outField(outField),
    .outHsync(outHsync), .outVsync(outVsync)
  );

endmodule

// File: rtl/pix_front_end_chk.sv
module pix_front_end_chk #(
  parameter int OUT_W  = 12,
  parameter int WIDE_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              hRef,
  input logic              vRef,
  input logic [2:0]        fmtSel,
  input logic              fillRep,
  input logic [OUT_W-1:0]  outData,
  input logic [WIDE_W-1:0] outWide,
  input logic              outValid,
  input logic              outField,
  input logic              outHsync
);

  a_r1_valid_needs_refs: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(hRef && vRef));

  a_r8_no_illegal_fmt: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(fmtSel) <= 3'd5));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == '0 && outWide == '0));

  a_r7_wide_quiet_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(fmtSel) == 3'd5) |-> outData == '0);

  a_r5_zero_pad10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(fmtSel) == 3'd1 || $past(fmtSel) == 3'd3) && !$past(fillRep))
      |-> outData[1:0] == 2'b00);

  a_r6_zero_pad8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(fmtSel) == 3'd2 && !$past(fillRep)) |-> outData[3:0] == 4'h0);

  a_r10_field_flip: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vRef) |=> (outField != $past(outField)));

  a_r2_hsync_delay: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hRef) |=> outHsync);

endmodule

bind pix_front_end pix_front_end_chk #(.OUT_W(OUT_W), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rstN(rstN), .hRef(hRef), .vRef(vRef), .fmtSel(fmtSel),
  .fillRep(fillRep), .outData(outData), .outWide(outWide),
  .outValid(outValid), .outField(outField), .outHsync(outHsync)
);

// File: tb/pix_front_end_tb.sv
module pix_front_end_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] pixData = '0;
  logic        hRef = 1'b0, vRef = 1'b0;
  logic [2:0]  fmtSel = '0;
  logic        fillRep = 1'b0, cropEn = 1'b0;
  logic [11:0] hStart = '0, hEnd = '0, vStart = '0, vEnd = '0;
  logic [11:0] outData;
  logic [39:0] outWide;
  logic        outValid, outField, outHsync, outVsync;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string curTag = "R4";

  typedef struct {
    logic        valid;
    logic [11:0] data;
    logic [39:0] wide;
    logic        hs, vs, field;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // bench reference state
  logic mPrevH = 1'b0, mPrevV = 1'b0, mField = 1'b0;
  int   mRun = 0, mLine = 0;

  always #10 clk = ~clk;

  pix_front_end u_dut (
    .clk(clk), .rstN(rstN), .pixData(pixData), .hRef(hRef), .vRef(vRef),
    .fmtSel(fmtSel), .fillRep(fillRep), .cropEn(cropEn), .hStart(hStart),
    .hEnd(hEnd), .vStart(vStart), .vEnd(vEnd), .outData(outData),
    .outWide(outWide), .outValid(outValid), .outField(outField),
    .outHsync(outHsync), .outVsync(outVsync)
  );

  function automatic logic [11:0] alignRef(logic [2:0] f, logic rep, logic [39:0] d);
    case (f)
      3'd1, 3'd3: return {d[9:0], rep ? d[9:8] : 2'b00};
      3'd2:       return {d[7:0], rep ? d[7:4] : 4'h0};
      default:    return d[11:0];
    endcase
  endfunction

  // drive one cycle of stimulus and push what the outputs must show next cycle
  task automatic drive(logic h, logic v, logic [39:0] d);
    exp_t e;
    int col, line;
    logic hr, hf, vr, acc;
    @(negedge clk);
    hRef = h; vRef = v; pixData = d;
    hr = h & ~mPrevH; hf = ~h & mPrevH; vr = v & ~mPrevV;
    col  = hr ? 0 : mRun;
    line = vr ? 0 : mLine;
    if (h) mRun = col + 1;
    if (vr) mLine = 0; else if (v && hf) mLine = mLine + 1;
    if (vr) mField = ~mField;
    mPrevH = h; mPrevV = v;
    acc = h && v && (fmtSel <= 3'd5) &&
          (!cropEn || (col >= hStart && col <= hEnd && line >= vStart && line <= vEnd));
    e.valid = acc;
    e.data  = (acc && fmtSel != 3'd5) ? alignRef(fmtSel, fillRep, d) : 12'h0;
    e.wide  = (acc && fmtSel == 3'd5) ? d : 40'h0;
    e.hs = h; e.vs = v; e.field = mField;
    e.tag = curTag;
    sbq.push_back(e);
  endtask

  function automatic logic [39:0] rnd40();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[39:0];
  endfunction

  task automatic frame(int lines, int pix, bit together);
    if (!together) drive(1'b0, 1'b1, rnd40());
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < pix; p++) drive(1'b1, 1'b1, rnd40());
      drive(1'b0, 1'b1, rnd40());
      drive(1'b0, 1'b1, rnd40());
    end
    drive(1'b0, 1'b0, rnd40());
    drive(1'b0, 1'b0, rnd40());
  endtask

  task automatic setFmt(logic [2:0] f, logic rep, string tag);
    @(negedge clk);
    fmtSel = f; fillRep = rep; curTag = tag;
  endtask

  // monitor: compare outputs against the queued expectation after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (outValid !== e.valid) begin
          errors++;
          $display("FAIL R2 %s valid act=%0b exp=%0b", e.tag, outValid, e.valid);
        end else if (outData !== e.data) begin
          errors++;
          $display("FAIL %s R9 data act=%h exp=%h", e.tag, outData, e.data);
        end else if (outWide !== e.wide) begin
          errors++;
          $display("FAIL %s R9 wide act=%h exp=%h", e.tag, outWide, e.wide);
        end else if (outHsync !== e.hs || outVsync !== e.vs || outField !== e.field) begin
          errors++;
          $display("FAIL R10 flags act=%0b%0b%0b exp=%0b%0b%0b",
                   outHsync, outVsync, outField, e.hs, e.vs, e.field);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: drive busy inputs during reset, outputs must stay zero
    hRef = 1'b1; vRef = 1'b1; pixData = 40'hFF_FFFF_FFFF; fmtSel = 3'd5;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0 || outWide !== '0 ||
        outField !== 1'b0 || outHsync !== 1'b0 || outVsync !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs act=%0b/%h/%h exp=0", outValid, outData, outWide);
    end
    hRef = 1'b0; vRef = 1'b0; fmtSel = 3'd0;
    @(negedge clk);
    rstN = 1'b1;

    setFmt(3'd0, 1'b0, "R4"); frame(2, 4, 1'b0);
    setFmt(3'd4, 1'b1, "R4"); frame(2, 3, 1'b0);
    setFmt(3'd1, 1'b0, "R5"); frame(2, 3, 1'b0);
    setFmt(3'd1, 1'b1, "R5"); frame(2, 3, 1'b0);
    setFmt(3'd3, 1'b1, "R5"); frame(1, 4, 1'b0);
    setFmt(3'd3, 1'b0, "R5"); frame(1, 4, 1'b0);
    setFmt(3'd2, 1'b0, "R6"); frame(2, 3, 1'b0);
    setFmt(3'd2, 1'b1, "R6"); frame(2, 3, 1'b0);
    setFmt(3'd5, 1'b0, "R7"); frame(2, 3, 1'b0);
    setFmt(3'd6, 1'b0, "R8"); frame(1, 4, 1'b0);
    setFmt(3'd7, 1'b1, "R8"); frame(1, 4, 1'b0);

    // R1: one reference without the other never yields a pixel
    setFmt(3'd0, 1'b0, "R1");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, rnd40());
    drive(1'b0, 1'b0, rnd40());
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, rnd40());
    drive(1'b0, 1'b0, rnd40());

    // R3: interior window, inclusive bounds on both axes
    setFmt(3'd0, 1'b0, "R3");
    @(negedge clk);
    cropEn = 1'b1; hStart = 12'd1; hEnd = 12'd3; vStart = 12'd1; vEnd = 12'd2;
    frame(4, 6, 1'b0);

    // R3: frame and line start on the same edge, one-pixel window at origin
    @(negedge clk);
    hStart = 12'd0; hEnd = 12'd0; vStart = 12'd0; vEnd = 12'd0;
    frame(3, 3, 1'b1);
    setFmt(3'd1, 1'b1, "R3");
    frame(2, 2, 1'b1);

    @(negedge clk);
    cropEn = 1'b0;
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule